// File: doc/BRIEF.md
# Slow-Tick Register Write Synchronizer

This block stands between a fast processor bus and a small bank of registers that belong to a slow timekeeping domain. A bus write aimed at one of those registers is not applied at once. The block captures the address and the data word in a single-entry shadow buffer and raises a pending flag. On the next slow tick it copies the word into the register bank, clears the pending flag and sets a sticky complete flag. Until that tick, a read of the register returns the value it held before the write.

Only one write can be outstanding. A second write to the slow bank is silently discarded while the first is still pending. Software sees this through the pending and complete flags in a status word. Writes to the status word bypass the synchronizer: a 1 in the complete bit clears that flag on the next clock edge. The commit point follows a prescaled tick (nominally once per second) when prescaling is enabled, and the raw oscillator tick otherwise. Each tick is modelled as a one-cycle enable. When its enable input is high, the complete flag drives an interrupt line.

Top module: `slow_wr_sync`

## Requirements
- R1: After a clock edge with `rst_n` low, every slow register reads 0, and `write_pending`, `write_complete` and `cmpl_irq` are 0.
- R2: A write to address 0..NREG-1 made while nothing is pending is accepted, and `write_pending` is 1 after that edge. Reads of the target register keep returning the previously committed value until the commit.
- R3: With `prescale_en`=1, the first `sec_tick` cycle after acceptance commits the shadow word into the register. In that same edge `write_pending` falls and `write_complete` rises. `raw_tick` has no effect in this mode.
- R4: With `prescale_en`=0, `raw_tick` is the commit point and `sec_tick` has no effect.
- R5: A slow-register write that arrives while a write is pending is dropped, including one in the very cycle of the commit. The register bank and the later commit are unaffected by it.
- R6: A write to the status address (NREG) with bit 15 of the data at 1 clears `write_complete` on that edge, even while a write is pending. Bit 15 at 0 leaves it unchanged, and no status write can change `write_pending`.
- R7: If a commit and a status clear fall on the same edge, `write_complete` ends up 1.
- R8: `cmpl_irq` equals `write_complete` AND `cmpl_irq_en`, combinationally.
- R9: A read of the status address returns `write_complete` in bit 15, `write_pending` in bit 14 and 0 in every other bit.
- R10: Writes to addresses above NREG are ignored, and reads of those addresses return 0.
- R11: A tick in the same cycle as the write that gets accepted does not commit it; the commit waits for a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle prescaled slow tick |
| raw_tick | input | 1 | One-cycle raw oscillator tick |
| prescale_en | input | 1 | 1 selects sec_tick as commit point, 0 selects raw_tick |
| cmpl_irq_en | input | 1 | Interrupt enable for the complete flag |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Register address (AW = clog2(NREG+2)) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| write_pending | output | 1 | A shadowed write awaits its tick |
| write_complete | output | 1 | Sticky: a commit happened since last clear |
| cmpl_irq | output | 1 | Complete interrupt request |

## Verification
The assertions take for granted that `bus_wr` is a one-cycle strobe whose address and data are valid in that cycle. They also assume that each tick input is a clean one-cycle enable, sampled in the fast clock domain, and that `prescale_en` is stable around the tick it selects. The stimulus drives every input at the falling clock edge, so each value is settled before the rising edge that samples it. The long mixed phase draws ticks, writes and clears at random and can assert both ticks in one cycle. Because commit selection uses only the tick chosen by `prescale_en`, that case is still legal, and the comparison with the reference model confirms that the other tick is ignored.

// File: rtl/slow_sync_pkg.sv
// Package: shared constants and types for the slow-tick write synchronizer.
// Assumes a status word of at least 16 bits.
package slow_sync_pkg;
    // Status word bit positions decoded by software
    localparam int CMPL_BIT = 15;
    localparam int PEND_BIT = 14;

    // Which tick acts as the commit point
    typedef enum logic [0:0] {
        TICK_RAW       = 1'b0,
        TICK_PRESCALED = 1'b1
    } tick_src_e;
endpackage

// File: rtl/sws_tick_select.sv
// Module: sws_tick_select
// Picks the commit tick from the prescaled and raw tick enables.
// Assumes both inputs are one-cycle pulses in the clk domain.
module sws_tick_select
    import slow_sync_pkg::*;
(
    input  logic prescale_en,
    input  logic sec_tick,
    input  logic raw_tick,
    output logic tick_o
);
    tick_src_e src;

    // Decode the source and route the matching tick
    always_comb begin
        src = tick_src_e'(prescale_en);
        unique case (src)
            TICK_PRESCALED: tick_o = sec_tick;
            default:        tick_o = raw_tick;
        endcase
    end
endmodule

// File: rtl/sws_shadow_buf.sv
// Module: sws_shadow_buf
// Single-entry shadow for one slow-domain write: captures address and data
// when idle, holds them while pending, and flags commit on the next tick.
// Assumes wr_en is a one-cycle strobe; writes while pending are dropped.
module sws_shadow_buf #(
    parameter int NREG = 4,
    parameter int DW   = 16,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          tick,
    output logic          pend_o,
    output logic          commit_o,
    output logic [AW-1:0] sh_addr_o,
    output logic [DW-1:0] sh_data_o
);
    localparam logic [AW-1:0] LAST_SLOW = AW'(NREG - 1);

    logic          pend_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          to_slow;
    logic          accept;

    // Classify the incoming write
    always_comb begin
        to_slow  = wr_en && (wr_addr <= LAST_SLOW);
        accept   = to_slow && !pend_q;
        commit_o = pend_q && tick;
    end

    // Pending flag: set on accept, cleared on commit
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (commit_o) pend_q <= 1'b0;
        else if (accept)   pend_q <= 1'b1;
    end

    // Shadow storage: loads only when an accept occurs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    assign pend_o    = pend_q;
    assign sh_addr_o = addr_q;
    assign sh_data_o = data_q;

    // R2
    accept_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr <= LAST_SLOW) && !pend_o) |=> pend_o);
    // R5
    shadow_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |=> ($stable(sh_addr_o) && $stable(sh_data_o)));
    // R3
    pend_waits_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !tick) |=> pend_o);
endmodule

// File: rtl/sws_reg_bank.sv
// Module: sws_reg_bank
// Committed slow-domain register bank. A register changes only when a
// commit names it. Reads return committed values, 0 out of range.
module sws_reg_bank #(
    parameter int NREG = 4,
    parameter int DW   = 16,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [NREG*DW-1:0] flat;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;

        // One committed register, loaded when the commit targets it
        always_ff @(posedge clk) begin
            if (!rst_n)                              q <= '0;
            else if (commit && (c_addr == AW'(g)))   q <= c_data;
        end

        assign flat[g*DW +: DW] = q;
    end

    // Read multiplexer over the committed bank
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = flat[i*DW +: DW];
        end
    end

    // R2
    bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(flat));
endmodule

// File: rtl/sws_status.sv
// Module: sws_status
// Sticky complete flag with immediate write-one-to-clear, status word
// assembly and interrupt gating. Set wins over a same-edge clear.
// Assumes DW >= 16.
module sws_status
    import slow_sync_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 16,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          pend,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_en,
    output logic          cmpl_o,
    output logic          irq_o,
    output logic [DW-1:0] stat_word
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NREG);

    logic cmpl_q;
    logic clr;

    // Detect a write-one-to-clear of the complete bit
    always_comb clr = wr_en && (wr_addr == STAT_ADDR) && wr_data[CMPL_BIT];

    // Complete flag: commit sets it, clear resets it, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)      cmpl_q <= 1'b0;
        else if (commit) cmpl_q <= 1'b1;
        else if (clr)    cmpl_q <= 1'b0;
    end

    // Assemble status word and gate the interrupt
    always_comb begin
        stat_word           = '0;
        stat_word[CMPL_BIT] = cmpl_q;
        stat_word[PEND_BIT] = pend;
        irq_o               = cmpl_q && irq_en;
    end

    assign cmpl_o = cmpl_q;

    // R3 R7
    commit_sets_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> cmpl_o);
    // R6
    clear_drops_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == STAT_ADDR) && wr_data[CMPL_BIT] && !commit) |=> !cmpl_o);
    // R6
    cmpl_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmpl_o) |-> $past(pend));
endmodule

// File: rtl/slow_wr_sync.sv
// Module: slow_wr_sync (top)
// Bus-side write synchronizer for a slow-tick register bank. Slow writes
// pass through a one-entry shadow and commit on the selected tick. Status
// writes act at once. Assumes one-cycle ticks sampled in the clk domain.
module slow_wr_sync #(
    parameter  int NREG = 4,
    parameter  int DW   = 16,
    localparam int AW   = $clog2(NREG + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          raw_tick,
    input  logic          prescale_en,
    input  logic          cmpl_irq_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          write_pending,
    output logic          write_complete,
    output logic          cmpl_irq
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NREG);

    logic          tick;
    logic          commit;
    logic [AW-1:0] sh_addr;
    logic [DW-1:0] sh_data;
    logic [DW-1:0] bank_rd;
    logic [DW-1:0] stat_word;

    sws_tick_select u_tick (
        .prescale_en (prescale_en),
        .sec_tick    (sec_tick),
        .raw_tick    (raw_tick),
        .tick_o      (tick)
    );

    sws_shadow_buf #(.NREG(NREG), .DW(DW), .AW(AW)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .tick      (tick),
        .pend_o    (write_pending),
        .commit_o  (commit),
        .sh_addr_o (sh_addr),
        .sh_data_o (sh_data)
    );

    sws_reg_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .c_addr  (sh_addr),
        .c_data  (sh_data),
        .rd_addr (bus_addr),
        .rd_data (bank_rd)
    );

    sws_status #(.NREG(NREG), .DW(DW), .AW(AW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .pend      (write_pending),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .irq_en    (cmpl_irq_en),
        .cmpl_o    (write_complete),
        .irq_o     (cmpl_irq),
        .stat_word (stat_word)
    );

    // Read-back multiplexer: status word or committed bank (0 above map)
    always_comb begin
        if (bus_addr == STAT_ADDR) bus_rdata = stat_word;
        else                       bus_rdata = bank_rd;
    end

    // R4
    raw_mode_no_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prescale_en && !raw_tick && write_pending) |=> write_pending);
    // R10
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > STAT_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_slow_wr_sync.sv
module tb_slow_wr_sync;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int DW         = 16;
    localparam int AW         = 3;
    localparam int WDOG_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0, raw_tick = 1'b0, prescale_en = 1'b1;
    logic          cmpl_irq_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          write_pending, write_complete, cmpl_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic [DW-1:0] mreg [NREG];
    logic          m_pend, m_cmpl;
    logic [AW-1:0] m_sa;
    logic [DW-1:0] m_sd;

    slow_wr_sync #(.NREG(NREG), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .raw_tick(raw_tick),
        .prescale_en(prescale_en), .cmpl_irq_en(cmpl_irq_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .write_pending(write_pending), .write_complete(write_complete),
        .cmpl_irq(cmpl_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        logic tk, cm, ac, cl;
        if (!rst_n) begin
            m_pend = 0; m_cmpl = 0; m_sa = '0; m_sd = '0;
            for (int i = 0; i < NREG; i++) mreg[i] = '0;
        end else begin
            tk = prescale_en ? sec_tick : raw_tick;
            cm = m_pend && tk;
            ac = bus_wr && (int'(bus_addr) < NREG) && !m_pend;
            cl = bus_wr && (int'(bus_addr) == NREG) && bus_wdata[15];
            if (cm) begin mreg[m_sa] = m_sd; m_pend = 0; end
            if (ac) begin m_pend = 1; m_sa = bus_addr; m_sd = bus_wdata; end
            if (cm) m_cmpl = 1; else if (cl) m_cmpl = 0;
        end
    end

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = '0;
        if (int'(a) < NREG) v = mreg[a];
        else if (int'(a) == NREG) begin v[15] = m_cmpl; v[14] = m_pend; end
        return v;
    endfunction

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("pending", DW'(write_pending), DW'(m_pend));
        chk("complete", DW'(write_complete), DW'(m_cmpl));
        chk("irq", DW'(cmpl_irq), DW'(m_cmpl && cmpl_irq_en));
        chk("rdata", bus_rdata, exp_rd(bus_addr));
    endtask

    // one clock: drive inputs, then compare after the rising edge
    task automatic cyc(input logic wr, input int a, input logic [DW-1:0] d,
                       input logic st, input logic rt);
        bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
        sec_tick = st; raw_tick = rt;
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog: counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) cyc(0, 0, '0, 0, 0);
        for (int a = 0; a < 8; a++) cyc(0, a, '0, 0, 0);
        rst_n = 1'b1;

        // R2 accept; R3 raw tick ignored in prescaled mode
        cur_req = "R2";
        cyc(1, 1, 16'hA5A5, 0, 0);
        cyc(0, 1, '0, 0, 0);
        cur_req = "R3";
        cyc(0, 1, '0, 0, 1);
        cyc(0, 1, '0, 0, 1);
        cyc(0, 1, '0, 1, 0);
        cyc(0, 4, '0, 0, 0);

        // R11 tick in the accept cycle does not commit
        cur_req = "R11";
        cyc(1, 2, 16'h1234, 1, 0);
        cyc(0, 2, '0, 0, 0);
        cyc(0, 2, '0, 1, 0);
        cyc(0, 2, '0, 0, 0);

        // R5 drops while pending, including on the commit cycle
        cur_req = "R5";
        cyc(1, 0, 16'h0F0F, 0, 0);
        cyc(1, 0, 16'hDEAD, 0, 0);
        cyc(1, 3, 16'hBEEF, 0, 0);
        cyc(1, 3, 16'hCAFE, 1, 0);
        cyc(0, 3, '0, 0, 0);
        cyc(0, 0, '0, 0, 0);

        // R6 clear only with bit 15; clear while pending
        cur_req = "R6";
        cyc(1, 4, 16'h4000, 0, 0);
        cyc(1, 4, 16'h8000, 0, 0);
        cyc(0, 4, '0, 1, 0);
        cyc(1, 1, 16'h5555, 0, 0);
        cyc(0, 4, '0, 1, 0);
        cyc(1, 3, 16'h7777, 0, 0);
        cyc(1, 4, 16'hFFFF, 0, 0);
        cyc(0, 4, '0, 0, 0);

        // R7 commit and clear on the same edge
        cur_req = "R7";
        cyc(1, 4, 16'h8000, 1, 0);
        cyc(0, 4, '0, 0, 0);
        cyc(0, 3, '0, 0, 0);

        // R4 raw mode
        cur_req = "R4";
        prescale_en = 1'b0;
        cyc(1, 2, 16'h2222, 0, 0);
        cyc(0, 2, '0, 1, 0);
        cyc(0, 2, '0, 1, 0);
        cyc(0, 2, '0, 0, 1);
        cyc(0, 4, '0, 0, 0);
        prescale_en = 1'b1;

        // R8 interrupt gating
        cur_req = "R8";
        cmpl_irq_en = 1'b1;
        cyc(0, 4, '0, 0, 0);
        cyc(1, 4, 16'h8000, 0, 0);
        cyc(1, 0, 16'h0101, 0, 0);
        cyc(0, 0, '0, 1, 0);
        cmpl_irq_en = 1'b0;
        cyc(0, 0, '0, 0, 0);

        // R9 status layout; R10 out-of-map
        cur_req = "R9";
        cyc(1, 1, 16'h9999, 0, 0);
        cyc(0, 4, '0, 0, 0);
        cyc(0, 4, '0, 1, 0);
        cur_req = "R10";
        cyc(1, 5, 16'hFFFF, 0, 0);
        cyc(1, 7, 16'hFFFF, 1, 1);
        cyc(0, 6, '0, 0, 0);
        cyc(0, 5, '0, 0, 0);
        for (int a = 0; a < NREG; a++) cyc(0, a, '0, 0, 0);

        // mixed random traffic, R5 and friends
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            prescale_en = ($urandom_range(0, 7) != 0);
            cmpl_irq_en = $urandom_range(0, 1) != 0;
            cyc($urandom_range(0, 2) != 0, $urandom_range(0, 7),
                DW'($urandom), $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0);
        end

        finish_run();
    end
endmodule